// File: doc/BRIEF.md
# Stream-to-Memory Packet DMA Writer

This block takes one transfer description (a destination byte address, a byte limit and a small set of control bits). It then copies 32-bit beats from a valid/ready stream into memory through a single-beat write master that honours waitrequest. Each beat lands four bytes above the one before it. A transfer ends in one of two ways. In packet mode it ends on the end-of-packet beat, and the byte limit only caps it. In length mode it ends on the byte limit alone.

A small register port carries the rest of the software interface. Software uses it to enable interrupts globally, to read and clear sticky status flags, and to halt the engine with a stop and reset sequence. The interrupt line is raised only when the global enable is set and the flag's own enable was given in the descriptor. A descriptor is taken only while the engine is idle. A descriptor that arrives at any other time is dropped, and a reject flag records it.

Top module: `pkt_dma_writer`

## Requirements
- R1: After reset, the status register reads 0, and sReady, mWrite and irq are all low.
- R2: Every accepted stream beat produces exactly one memory write with unchanged data. Writes come out in acceptance order. The k-th beat of a transfer (counting from 0) is written at descriptor address + 4*k.
- R3: While mWrite is high and mWaitReq is high:
  - mWrite, mAddr and mData hold their values.
  - sReady stays low.
- R4: When descriptor control bit 0 (end-on-EOP) is set, the transfer ends once the write of the beat carrying sEop has been accepted by memory. At that point status bit 2 (done) is set, and sReady stays low afterwards.
- R5: When end-on-EOP is clear, the transfer moves exactly descLen/4 beats, where descLen is a nonzero multiple of 4. In this mode sEop has no effect, and done is set at the end.
- R6: Byte cap in packet mode:
  - If end-on-EOP is set and the byte limit is used up without sEop, the transfer stops. Status bit 3 (early) is set and done is not set.
  - If sEop arrives on the beat that reaches the limit, the transfer ends normally and sets done.
- R7: Any accepted beat with sErr high sets status bit 4 (error).
- R8: Status bits 2 to 5 are sticky. Writing 1 to a bit at csrSel=1 clears that bit, and writing 0 leaves it unchanged.
- R9: irq is high only when both of these hold:
  - Control register bit 0 (global enable) is set.
  - At least one pending flag has its descriptor enable set. Descriptor control bit 1 enables done, bit 2 enables early and bit 3 enables error.
- R10: A descriptor is accepted only while the engine is idle (status bit 0, busy, is low) and not stopped. Any other descriptor is ignored and sets status bit 5 (reject).
- R11: Stop and reset commands:
  - Writing control bit 1 requests a stop. The engine halts after any pending write, status bit 1 (stopped) reads 1, and sReady stays low.
  - Writing control bit 2 returns the engine to idle and clears stopped. After that, a new descriptor is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descValid | input | 1 | Descriptor write strobe |
| descAddr | input | ADDR_W | Destination byte address |
| descLen | input | LEN_W | Byte limit |
| descCtrl | input | 4 | {irq error, irq early, irq done, end-on-EOP} |
| sValid | input | 1 | Stream beat valid |
| sReady | output | 1 | Stream beat ready |
| sData | input | DATA_W | Stream data |
| sEop | input | 1 | End of packet |
| sErr | input | 1 | Beat error sideband |
| mWrite | output | 1 | Memory write request |
| mAddr | output | ADDR_W | Memory byte address |
| mData | output | DATA_W | Memory write data |
| mWaitReq | input | 1 | Memory stall |
| csrWe | input | 1 | Register write strobe |
| csrSel | input | 1 | 0 = control, 1 = status |
| csrWdata | input | 6 | Register write data |
| csrRdata | output | 6 | Register read data for csrSel |
| irq | output | 1 | Interrupt |

## Verification
The in-line assertions check three things on every cycle:
- the write request and its address and data stay frozen under waitrequest;
- the address steps by four between back-to-back beats;
- the ready signal stays low while stopped, and the interrupt never rises without a pending flag.

Other behaviour needs whole sequences, so only the bench's scenarios can show it. That covers the choice between done and early when end-of-packet and the byte cap meet, end-of-packet being ignored in length mode, descriptors being rejected while busy or stopped, and the stop-poll-reset recovery. The scoreboard compares every write against the beats that were accepted, including under a stalling memory.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_STOP  = 2'd3
  } engState_t;

  typedef struct packed {
    logic load;   // capture descriptor address and limit
    logic beat;   // capture a stream beat into the write register
    logic flush;  // drop any pending write
  } dpStrobe_t;

  // descriptor control bits
  localparam int unsigned DC_EOP   = 0;
  localparam int unsigned DC_IDONE = 1;
  localparam int unsigned DC_IEARL = 2;
  localparam int unsigned DC_IERR  = 3;

  // control register bits
  localparam int unsigned CR_GIE   = 0;
  localparam int unsigned CR_STOP  = 1;
  localparam int unsigned CR_RST   = 2;

  // status register bits
  localparam int unsigned SR_BUSY  = 0;
  localparam int unsigned SR_STOP  = 1;
  localparam int unsigned SR_DONE  = 2;
  localparam int unsigned SR_EARL  = 3;
  localparam int unsigned SR_ERR   = 4;
  localparam int unsigned SR_REJ   = 5;
  localparam int unsigned SR_W     = 6;

endpackage

// File: rtl/pkt_dma_dpath.sv
module pkt_dma_dpath
  import pkt_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [DATA_W-1:0] sData,
  input  logic              sValid,
  input  logic              sReady,
  input  logic              mWaitReq,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData,
  output logic              capLast
);

  localparam int unsigned BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] nextAddr;
  logic [LEN_W-1:0]  bytesLeft;

  assign capLast = (bytesLeft <= LEN_W'(BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWrite    <= 1'b0;
      mAddr     <= '0;
      mData     <= '0;
      nextAddr  <= '0;
      bytesLeft <= '0;
    end else if (stb.flush) begin
      mWrite    <= 1'b0;
    end else if (stb.load) begin
      nextAddr  <= descAddr;
      bytesLeft <= descLen;
    end else if (stb.beat) begin
      mWrite    <= 1'b1;
      mAddr     <= nextAddr;
      mData     <= sData;
      nextAddr  <= nextAddr + ADDR_W'(BYTES);
      bytesLeft <= bytesLeft - LEN_W'(BYTES);
    end else if (mWrite && !mWaitReq) begin
      mWrite    <= 1'b0;
    end
  end

  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mWrite && mWaitReq && !stb.flush) |=> (mWrite && $stable(mAddr) && $stable(mData)));

  // R3
  no_accept_in_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sValid && sReady && mWrite && mWaitReq));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && mWrite && !stb.flush) |=> (mAddr == $past(mAddr) + ADDR_W'(BYTES)));

endmodule

// File: rtl/pkt_dma_ctrl.sv
module pkt_dma_ctrl
  import pkt_dma_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            descValid,
  input  logic [3:0]      descCtrl,
  input  logic            sValid,
  input  logic            sEop,
  input  logic            sErr,
  input  logic            mWrite,
  input  logic            mWaitReq,
  input  logic            capLast,
  input  logic            csrWe,
  input  logic            csrSel,
  input  logic [SR_W-1:0] csrWdata,
  output logic            sReady,
  output logic [SR_W-1:0] csrRdata,
  output logic            irq,
  output dpStrobe_t       stb
);

  engState_t state, stateNxt;
  logic gie, stopReq, endEop, earlyPend;
  logic enDone, enEarly, enErr;
  logic doneF, earlyF, errF, rejF;
  logic wrBusy, wrDone, accept, lastBeat, capHit, rstCmd, canLoad;

  assign wrBusy   = mWrite && mWaitReq;
  assign wrDone   = mWrite && !mWaitReq;
  assign sReady   = (state == ST_RUN) && !stopReq && !wrBusy;
  assign accept   = sValid && sReady;
  assign lastBeat = (endEop && sEop) || capLast;
  assign capHit   = endEop && capLast && !sEop;
  assign rstCmd   = csrWe && !csrSel && csrWdata[CR_RST];
  assign canLoad  = (state == ST_IDLE) && !stopReq && !rstCmd;

  always_comb begin
    stb       = '0;
    stb.flush = rstCmd;
    stb.load  = descValid && canLoad;
    stb.beat  = accept && !rstCmd;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (stopReq) stateNxt = ST_STOP;
                else if (descValid) stateNxt = ST_RUN;
      ST_RUN:   if (accept && lastBeat) stateNxt = ST_DRAIN;
                else if (stopReq && !wrBusy) stateNxt = ST_STOP;
      ST_DRAIN: if (wrDone) stateNxt = stopReq ? ST_STOP : ST_IDLE;
      ST_STOP:  stateNxt = ST_STOP;
      default:  stateNxt = ST_IDLE;
    endcase
    if (rstCmd) stateNxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      gie       <= 1'b0;
      stopReq   <= 1'b0;
      endEop    <= 1'b0;
      earlyPend <= 1'b0;
      enDone    <= 1'b0;
      enEarly   <= 1'b0;
      enErr     <= 1'b0;
      doneF     <= 1'b0;
      earlyF    <= 1'b0;
      errF      <= 1'b0;
      rejF      <= 1'b0;
    end else begin
      state <= stateNxt;
      if (csrWe && !csrSel) begin
        gie <= csrWdata[CR_GIE];
        if (csrWdata[CR_STOP]) stopReq <= 1'b1;
        if (csrWdata[CR_RST])  stopReq <= 1'b0;
      end
      if (stb.load) begin
        endEop    <= descCtrl[DC_EOP];
        enDone    <= descCtrl[DC_IDONE];
        enEarly   <= descCtrl[DC_IEARL];
        enErr     <= descCtrl[DC_IERR];
        earlyPend <= 1'b0;
      end
      if (accept && lastBeat) earlyPend <= capHit;
      // clear-on-one first, so a same-cycle set wins
      if (csrWe && csrSel) begin
        if (csrWdata[SR_DONE]) doneF  <= 1'b0;
        if (csrWdata[SR_EARL]) earlyF <= 1'b0;
        if (csrWdata[SR_ERR])  errF   <= 1'b0;
        if (csrWdata[SR_REJ])  rejF   <= 1'b0;
      end
      if (state == ST_DRAIN && wrDone && !rstCmd) begin
        if (earlyPend) earlyF <= 1'b1;
        else           doneF  <= 1'b1;
      end
      if (accept && sErr) errF <= 1'b1;
      if (descValid && !canLoad) rejF <= 1'b1;
    end
  end

  always_comb begin
    csrRdata = '0;
    if (csrSel) begin
      csrRdata[SR_BUSY] = (state == ST_RUN) || (state == ST_DRAIN);
      csrRdata[SR_STOP] = (state == ST_STOP);
      csrRdata[SR_DONE] = doneF;
      csrRdata[SR_EARL] = earlyF;
      csrRdata[SR_ERR]  = errF;
      csrRdata[SR_REJ]  = rejF;
    end else begin
      csrRdata[CR_GIE]  = gie;
    end
  end

  assign irq = gie && ((doneF && enDone) || (earlyF && enEarly) || (errF && enErr));

  // R11
  stopped_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> !sReady);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneF || earlyF || errF));

  // R6
  early_excludes_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlyF) |-> !$rose(doneF));

  // R4
  drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> !sReady);

endmodule

// File: rtl/pkt_dma_writer.sv
module pkt_dma_writer
  import pkt_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [3:0]        descCtrl,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  logic              sEop,
  input  logic              sErr,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData,
  input  logic              mWaitReq,
  input  logic              csrWe,
  input  logic              csrSel,
  input  logic [5:0]        csrWdata,
  output logic [5:0]        csrRdata,
  output logic              irq
);

  dpStrobe_t stb;
  logic      capLast;

  pkt_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .descCtrl(descCtrl),
    .sValid(sValid), .sEop(sEop), .sErr(sErr),
    .mWrite(mWrite), .mWaitReq(mWaitReq), .capLast(capLast),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata),
    .sReady(sReady), .csrRdata(csrRdata), .irq(irq), .stb(stb)
  );

  pkt_dma_dpath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .descAddr(descAddr), .descLen(descLen),
    .sData(sData), .sValid(sValid), .sReady(sReady), .mWaitReq(mWaitReq),
    .mWrite(mWrite), .mAddr(mAddr), .mData(mData), .capLast(capLast)
  );

endmodule

// File: tb/test_pkt_dma_writer.sv
module test_pkt_dma_writer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descValid = 1'b0;
  logic [31:0] descAddr = '0;
  logic [15:0] descLen = '0;
  logic [3:0]  descCtrl = '0;
  logic        sValid = 1'b0;
  logic        sReady;
  logic [31:0] sData = '0;
  logic        sEop = 1'b0;
  logic        sErr = 1'b0;
  logic        mWrite;
  logic [31:0] mAddr;
  logic [31:0] mData;
  logic        mWaitReq = 1'b0;
  logic        csrWe = 1'b0;
  logic        csrSel = 1'b1;
  logic [5:0]  csrWdata = '0;
  logic [5:0]  csrRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [63:0] expQ[$];
  logic [31:0] expAddr = '0;
  bit stallEn = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  pkt_dma_writer i_pkt_dma_writer (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .descAddr(descAddr), .descLen(descLen), .descCtrl(descCtrl),
    .sValid(sValid), .sReady(sReady), .sData(sData), .sEop(sEop), .sErr(sErr),
    .mWrite(mWrite), .mAddr(mAddr), .mData(mData), .mWaitReq(mWaitReq),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stall pattern
  always @(negedge clk) begin
    cyc++;
    mWaitReq = stallEn && ((cyc % 3) != 2);
  end

  // monitor: pre-edge values show the handshake taken at this edge
  always @(posedge clk) begin
    if (rstN && mWrite && mWaitReq)
      chk("R3 ready low in stall", {31'b0, sReady}, 32'd0);
    if (rstN && mWrite && !mWaitReq) begin
      if (expQ.size() == 0) chk("R2 unexpected write", mAddr, 32'hFFFF_FFFF);
      else begin
        logic [63:0] e;
        e = expQ.pop_front();
        chk("R2 write addr", mAddr, e[63:32]);
        chk("R2 write data", mData, e[31:0]);
      end
    end
  end

  task automatic csrWr(input logic sel, input logic [5:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrSel = sel; csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0; csrSel = 1'b1; csrWdata = '0;
  endtask

  task automatic rdStatus(output logic [5:0] v);
    @(negedge clk);
    #1 v = csrRdata;
  endtask

  task automatic giveDesc(input logic [31:0] a, input logic [15:0] len,
                          input logic [3:0] c, input bit track);
    @(negedge clk);
    descValid = 1'b1; descAddr = a; descLen = len; descCtrl = c;
    if (track) expAddr = a;
    @(negedge clk);
    descValid = 1'b0;
  endtask

  task automatic sendBeat(input logic [31:0] d, input bit eop, input bit er);
    @(negedge clk);
    sValid = 1'b1; sData = d; sEop = eop; sErr = er;
    forever begin
      @(posedge clk);
      if (sReady) break;
    end
    expQ.push_back({expAddr, d});
    expAddr += 32'd4;
    #1 sValid = 1'b0; sEop = 1'b0; sErr = 1'b0;
  endtask

  task automatic waitIdle();
    logic [5:0] v;
    for (int i = 0; i < 100; i++) begin
      rdStatus(v);
      if (!v[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdStatus(st);
    chk("R1 status", {26'b0, st}, 32'h0);
    chk("R1 sReady", {31'b0, sReady}, 32'd0);
    chk("R1 mWrite", {31'b0, mWrite}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);

    csrWr(1'b0, 6'b000001);

    // R4: packet mode ends on EOP
    giveDesc(32'h1000, 16'd32, 4'b0011, 1'b1);
    for (int i = 0; i < 4; i++) sendBeat(32'hA000 + i, i == 3, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R4 done after eop", {26'b0, st}, 32'h04);
    chk("R9 irq done enabled", {31'b0, irq}, 32'd1);
    chk("R4 ready low after", {31'b0, sReady}, 32'd0);
    chk("R2 all written", expQ.size(), 32'd0);
    csrWr(1'b1, 6'b000100);
    rdStatus(st);
    chk("R8 done cleared", {26'b0, st}, 32'h0);
    chk("R8 irq dropped", {31'b0, irq}, 32'd0);

    // R5: length mode ignores EOP
    giveDesc(32'h2000, 16'd12, 4'b0000, 1'b1);
    for (int i = 0; i < 3; i++) sendBeat(32'hB000 + i, i == 0, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R5 done after len", {26'b0, st}, 32'h04);
    chk("R5 all beats", expQ.size(), 32'd0);
    chk("R9 irq done disabled", {31'b0, irq}, 32'd0);
    csrWr(1'b1, 6'b111100);

    // R6: cap in packet mode, early irq off then on
    giveDesc(32'h3000, 16'd8, 4'b0001, 1'b1);
    for (int i = 0; i < 2; i++) sendBeat(32'hC000 + i, 1'b0, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R6 early not done", {26'b0, st}, 32'h08);
    chk("R9 irq early disabled", {31'b0, irq}, 32'd0);
    csrWr(1'b1, 6'b111100);
    giveDesc(32'h3100, 16'd8, 4'b0101, 1'b1);
    for (int i = 0; i < 2; i++) sendBeat(32'hC100 + i, 1'b0, 1'b0);
    waitIdle();
    chk("R9 irq early enabled", {31'b0, irq}, 32'd1);
    csrWr(1'b1, 6'b111100);
    giveDesc(32'h3200, 16'd8, 4'b0001, 1'b1);
    for (int i = 0; i < 2; i++) sendBeat(32'hC200 + i, i == 1, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R6 eop on cap beat is done", {26'b0, st}, 32'h04);
    csrWr(1'b1, 6'b111100);

    // R7: error flag and global gating
    giveDesc(32'h4000, 16'd8, 4'b1001, 1'b1);
    sendBeat(32'hD000, 1'b0, 1'b1);
    sendBeat(32'hD001, 1'b1, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R7 error and done", {26'b0, st}, 32'h14);
    chk("R9 irq error", {31'b0, irq}, 32'd1);
    csrWr(1'b0, 6'b000000);
    chk("R9 global off", {31'b0, irq}, 32'd0);
    csrWr(1'b0, 6'b000001);
    chk("R9 global on", {31'b0, irq}, 32'd1);
    csrWr(1'b1, 6'b111100);

    // R3: stalling memory
    stallEn = 1'b1;
    giveDesc(32'h5000, 16'd24, 4'b0001, 1'b1);
    for (int i = 0; i < 6; i++) sendBeat(32'hE000 + i, i == 5, 1'b0);
    waitIdle();
    stallEn = 1'b0;
    rdStatus(st);
    chk("R3 done under stall", {26'b0, st}, 32'h04);
    chk("R3 all written", expQ.size(), 32'd0);
    csrWr(1'b1, 6'b111100);

    // R10: descriptor while busy
    giveDesc(32'h6000, 16'd8, 4'b0001, 1'b1);
    giveDesc(32'h7000, 16'd8, 4'b0001, 1'b0);
    rdStatus(st);
    chk("R10 reject while busy", {26'b0, st}, 32'h21);
    for (int i = 0; i < 2; i++) sendBeat(32'hF000 + i, i == 1, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R10 first kept", {26'b0, st}, 32'h24);
    csrWr(1'b1, 6'b111100);

    // R11: stop, poll, reset
    giveDesc(32'h8000, 16'd16, 4'b0001, 1'b1);
    sendBeat(32'h1234_5678, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    csrWr(1'b0, 6'b000011);
    for (int i = 0; i < 20; i++) begin
      rdStatus(st);
      if (st[1]) break;
    end
    chk("R11 stopped", {26'b0, st}, 32'h02);
    @(negedge clk); sValid = 1'b1; sData = 32'hDEAD;
    repeat (3) @(negedge clk);
    chk("R11 ready low stopped", {31'b0, sReady}, 32'd0);
    chk("R11 no write stopped", {31'b0, mWrite}, 32'd0);
    sValid = 1'b0;
    giveDesc(32'h9000, 16'd4, 4'b0001, 1'b0);
    rdStatus(st);
    chk("R10 reject while stopped", {26'b0, st}, 32'h22);
    csrWr(1'b0, 6'b000101);
    rdStatus(st);
    chk("R11 reset to idle", {26'b0, st}, 32'h20);
    csrWr(1'b1, 6'b111100);
    giveDesc(32'h9000, 16'd4, 4'b0001, 1'b1);
    sendBeat(32'h0BAD_F00D, 1'b1, 1'b0);
    waitIdle();
    rdStatus(st);
    chk("R11 runs after reset", {26'b0, st}, 32'h04);
    chk("R2 queue empty", expQ.size(), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule